// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This unit computes the data-memory address and the pointer write-back for the load and store operations of a small 8-bit processor core. Three 16-bit pointers, X, Y and Z, and a stack pointer are supplied from the register file. The unit turns one request into a memory address and a read or write strobe. Where the addressing mode changes a pointer, it also produces the new pointer value, a write enable and the code of the pointer to update. A busy and done handshake follows the cycle count of the operation.

Modes supported: plain indirect, post-increment, pre-decrement, displacement from Y or Z with an unsigned 6-bit offset, direct addressing with a 16-bit address, a program-memory read through Z whose byte goes to register R0, and stack push and pop. Memory operations take two cycles and the program-memory read takes three. The unit computes no status flags, so it leaves them unchanged. A request is taken only while the unit is idle and only if its mode and pointer fit together.

Top module: `ptr_agu`

## Requirements
- R1: After synchronous reset, busy, done, mem_rd, mem_wr, prog_rd, wb_we and r0_we are all 0.
- R2: A request is accepted only on a clock edge where req_valid is 1 and busy is 0. Requests made while busy are ignored, and so are the illegal combinations: ptr_sel 3 with modes 0 to 3, and ptr_sel 0 (X) with mode 3. An ignored request leaves busy at 0 and raises no strobe.
- R3: Mode 0 (indirect) addresses memory at the selected pointer (ptr_sel 0=X, 1=Y, 2=Z) and raises no wb_we.
- R4: Mode 1 (post-increment) addresses at the pointer value and writes back pointer+1, wrapping from 0xFFFF to 0x0000.
- R5: Mode 2 (pre-decrement) addresses at pointer-1 and writes back that same value, wrapping from 0x0000 to 0xFFFF.
- R6: Mode 3 (displacement) addresses at Y or Z plus the zero-extended 6-bit disp (0 to 63), modulo 2^16, and raises no wb_we.
- R7: Mode 4 (direct) addresses at direct_addr, whatever ptr_sel is, and raises no wb_we.
- R8: For modes 0 to 4, is_store=1 raises mem_wr and is_store=0 raises mem_rd. The strobe is high only in the first cycle after acceptance, and at most one of mem_rd, mem_wr and prog_rd is ever high.
- R9: Modes 0 to 4, 6 and 7 keep busy high for 2 cycles and mode 5 for 3 cycles. done is high only in the last busy cycle, and mem_addr is held while busy.
- R10: Mode 5 (program read) addresses at Z, ignoring ptr_sel and is_store. It pulses prog_rd in the first cycle and r0_we in the last cycle, together with done.
- R11: Mode 6 (push) writes at the stack pointer and writes back SP-1. Mode 7 (pop) reads at SP+1 and writes back SP+1. Both ignore ptr_sel and is_store.
- R12: wb_we is high for one cycle, together with the data strobe. wb_sel names the pointer to update (0=X, 1=Y, 2=Z, 3=SP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| is_store | input | 1 | 1 = store, 0 = load (modes 0 to 4) |
| mode | input | 3 | Addressing mode code 0..7 |
| ptr_sel | input | 2 | Pointer select 0=X, 1=Y, 2=Z |
| disp | input | 6 | Unsigned displacement |
| direct_addr | input | 16 | Direct address |
| ptr_x | input | 16 | Current X value |
| ptr_y | input | 16 | Current Y value |
| ptr_z | input | 16 | Current Z value |
| ptr_sp | input | 16 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last cycle of the operation |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| prog_rd | output | 1 | Program-memory read strobe |
| wb_we | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to update |
| wb_val | output | 16 | New pointer value |
| r0_we | output | 1 | Write program byte into R0 |

## Verification
A wrong remaining-cycle count shows at the ports within three cycles of acceptance: done comes early or late, busy is dropped, or the next request is refused. A wrong address or write-back sum shows in the first busy cycle as a mismatch on mem_addr or wb_val. The most telling cases are the wrap points at 0x0000 and 0xFFFF and the largest displacement. A latched request that is not frozen while busy shows as mem_addr changing before done, because the bench drives different requests into the busy unit.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    M_IND     = 3'd0,
    M_POSTINC = 3'd1,
    M_PREDEC  = 3'd2,
    M_DISP    = 3'd3,
    M_DIRECT  = 3'd4,
    M_PROG    = 3'd5,
    M_PUSH    = 3'd6,
    M_POP     = 3'd7
  } agu_mode_e;

  localparam logic [1:0] SEL_X  = 2'd0;
  localparam logic [1:0] SEL_Y  = 2'd1;
  localparam logic [1:0] SEL_Z  = 2'd2;
  localparam logic [1:0] SEL_SP = 2'd3;

  typedef struct packed {
    logic       legal;
    logic [1:0] base;
    logic       rd;
    logic       wr;
    logic       prd;
    logic       we;
    logic       long_op;
  } agu_ctl_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  agu_mode_e  mode,
  input  logic [1:0] sel,
  input  logic       is_store,
  output agu_ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    unique case (mode)
      M_IND, M_POSTINC, M_PREDEC: begin
        ctl.legal = (sel != SEL_SP);
        ctl.base  = sel;
        ctl.rd    = !is_store;
        ctl.wr    = is_store;
        ctl.we    = (mode != M_IND);
      end
      M_DISP: begin
        ctl.legal = (sel == SEL_Y) || (sel == SEL_Z);
        ctl.base  = sel;
        ctl.rd    = !is_store;
        ctl.wr    = is_store;
      end
      M_DIRECT: begin
        ctl.legal = 1'b1;
        ctl.base  = sel;
        ctl.rd    = !is_store;
        ctl.wr    = is_store;
      end
      M_PROG: begin
        ctl.legal   = 1'b1;
        ctl.base    = SEL_Z;
        ctl.prd     = 1'b1;
        ctl.long_op = 1'b1;
      end
      M_PUSH: begin
        ctl.legal = 1'b1;
        ctl.base  = SEL_SP;
        ctl.wr    = 1'b1;
        ctl.we    = 1'b1;
      end
      M_POP: begin
        ctl.legal = 1'b1;
        ctl.base  = SEL_SP;
        ctl.rd    = 1'b1;
        ctl.we    = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int QW = 6
) (
  input  agu_mode_e       mode,
  input  logic [AW-1:0]   base,
  input  logic [QW-1:0]   disp,
  input  logic [AW-1:0]   direct_addr,
  output logic [AW-1:0]   addr,
  output logic [AW-1:0]   wb_val
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] inc_v, dec_v, disp_v;

  assign inc_v  = base + ONE;
  assign dec_v  = base - ONE;
  assign disp_v = base + AW'(disp);

  always_comb begin
    addr   = base;
    wb_val = base;
    unique case (mode)
      M_POSTINC: wb_val = inc_v;
      M_PREDEC:  begin addr = dec_v; wb_val = dec_v; end
      M_DISP:    addr = disp_v;
      M_DIRECT:  addr = direct_addr;
      M_PUSH:    wb_val = dec_v;
      M_POP:     begin addr = inc_v; wb_val = inc_v; end
      default:   ;
    endcase
  end
endmodule

// File: rtl/agu_seq.sv
module agu_seq
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CYC_MEM  = 2,
  parameter int CYC_PROG = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  agu_ctl_t      ctl,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] wb_in,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          prog_rd,
  output logic          wb_we,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val,
  output logic          r0_we
);
  localparam int CMAX = (CYC_PROG > CYC_MEM) ? CYC_PROG : CYC_MEM;
  localparam int CW   = (CMAX > 2) ? $clog2(CMAX) : 1;

  logic [CW-1:0] rem;
  logic          prog_q;
  logic          accept;

  assign accept = req_valid && !busy && ctl.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      rem      <= '0;
      prog_q   <= 1'b0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      prog_rd  <= 1'b0;
      wb_we    <= 1'b0;
      wb_sel   <= '0;
      wb_val   <= '0;
      r0_we    <= 1'b0;
    end else begin
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      prog_rd <= 1'b0;
      wb_we   <= 1'b0;
      r0_we   <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        done     <= 1'b0;
        rem      <= ctl.long_op ? CW'(CYC_PROG - 1) : CW'(CYC_MEM - 1);
        prog_q   <= ctl.prd;
        mem_addr <= addr_in;
        mem_rd   <= ctl.rd;
        mem_wr   <= ctl.wr;
        prog_rd  <= ctl.prd;
        wb_we    <= ctl.we;
        wb_sel   <= ctl.base;
        wb_val   <= wb_in;
      end else if (busy) begin
        if (rem == CW'(1)) begin
          done  <= 1'b1;
          rem   <= '0;
          r0_we <= prog_q;
        end else if (rem == '0) begin
          busy <= 1'b0;
          done <= 1'b0;
        end else begin
          rem <= rem - CW'(1);
        end
      end
    end
  end

  assert_strobe_first_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr || prog_rd) |-> (busy && !done));
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, prog_rd}));
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  assert_hold_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && $stable(mem_addr) && $stable(wb_sel)));
  assert_r0_last_R10: assert property (@(posedge clk) disable iff (rst)
    r0_we |-> done);
  assert_wb_with_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> (mem_rd || mem_wr));
endmodule

// File: rtl/ptr_agu.sv
module ptr_agu
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter int QW       = 6,
  parameter int CYC_MEM  = 2,
  parameter int CYC_PROG = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          is_store,
  input  logic [2:0]    mode,
  input  logic [1:0]    ptr_sel,
  input  logic [QW-1:0] disp,
  input  logic [AW-1:0] direct_addr,
  input  logic [AW-1:0] ptr_x,
  input  logic [AW-1:0] ptr_y,
  input  logic [AW-1:0] ptr_z,
  input  logic [AW-1:0] ptr_sp,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          prog_rd,
  output logic          wb_we,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val,
  output logic          r0_we
);
  localparam int NPTR = 4;

  agu_mode_e      mode_e;
  agu_ctl_t       ctl;
  logic [AW-1:0]  ptr_bank [NPTR];
  logic [AW-1:0]  base, addr_c, wb_c;

  assign mode_e = agu_mode_e'(mode);

  assign ptr_bank[SEL_X]  = ptr_x;
  assign ptr_bank[SEL_Y]  = ptr_y;
  assign ptr_bank[SEL_Z]  = ptr_z;
  assign ptr_bank[SEL_SP] = ptr_sp;

  agu_decode u_dec (
    .mode     (mode_e),
    .sel      (ptr_sel),
    .is_store (is_store),
    .ctl      (ctl)
  );

  assign base = ptr_bank[ctl.base];

  agu_addr_calc #(.AW(AW), .QW(QW)) u_calc (
    .mode        (mode_e),
    .base        (base),
    .disp        (disp),
    .direct_addr (direct_addr),
    .addr        (addr_c),
    .wb_val      (wb_c)
  );

  agu_seq #(.AW(AW), .CYC_MEM(CYC_MEM), .CYC_PROG(CYC_PROG)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ctl       (ctl),
    .addr_in   (addr_c),
    .wb_in     (wb_c),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .prog_rd   (prog_rd),
    .wb_we     (wb_we),
    .wb_sel    (wb_sel),
    .wb_val    (wb_val),
    .r0_we     (r0_we)
  );

  // Stack write-back is one below the write address, or equal to the read address.
  assert_stack_wb_R11: assert property (@(posedge clk) disable iff (rst)
    (wb_we && wb_sel == SEL_SP) |->
      ((mem_wr && wb_val == mem_addr - AW'(1)) || (mem_rd && wb_val == mem_addr)));
  assert_busy_idle_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !wb_we));
endmodule

// File: tb/ptr_agu_tb.sv
module ptr_agu_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, is_store;
  logic [2:0]  mode;
  logic [1:0]  ptr_sel;
  logic [5:0]  disp;
  logic [15:0] direct_addr, ptr_x, ptr_y, ptr_z, ptr_sp;
  logic        busy, done, mem_rd, mem_wr, prog_rd, wb_we, r0_we;
  logic [1:0]  wb_sel;
  logic [15:0] mem_addr, wb_val;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ptr_agu u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .is_store(is_store),
    .mode(mode), .ptr_sel(ptr_sel), .disp(disp), .direct_addr(direct_addr),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .ptr_sp(ptr_sp),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .prog_rd(prog_rd), .wb_we(wb_we), .wb_sel(wb_sel),
    .wb_val(wb_val), .r0_we(r0_we)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Expected behaviour from the requirements.
  function automatic void model(
    input logic [2:0] m, input logic [1:0] s, input logic st,
    input logic [15:0] x, input logic [15:0] y, input logic [15:0] z,
    input logic [15:0] sp, input logic [5:0] q, input logic [15:0] k,
    output bit legal, output logic [15:0] a, output bit rd, output bit wr,
    output bit prd, output bit we, output logic [1:0] ws,
    output logic [15:0] wv, output int ncyc);
    logic [15:0] p;
    p = (s == 2'd0) ? x : (s == 2'd1) ? y : z;
    legal = 1; rd = 0; wr = 0; prd = 0; we = 0; ws = s; wv = 16'h0; ncyc = 2; a = 16'h0;
    case (m)
      3'd0: begin legal = (s != 3); a = p; rd = !st; wr = st; end
      3'd1: begin legal = (s != 3); a = p; rd = !st; wr = st; we = 1; wv = p + 16'd1; end
      3'd2: begin legal = (s != 3); a = p - 16'd1; rd = !st; wr = st; we = 1; wv = a; end
      3'd3: begin legal = (s == 1 || s == 2); a = p + {10'd0, q}; rd = !st; wr = st; end
      3'd4: begin a = k; rd = !st; wr = st; end
      3'd5: begin a = z; prd = 1; ncyc = 3; end
      3'd6: begin a = sp; wr = 1; we = 1; ws = 3; wv = sp - 16'd1; end
      default: begin a = sp + 16'd1; rd = 1; we = 1; ws = 3; wv = a; end
    endcase
  endfunction

  task automatic run_op(input logic [2:0] m, input logic [1:0] s, input logic st,
                        input logic [15:0] x, input logic [15:0] y,
                        input logic [15:0] z, input logic [15:0] sp,
                        input logic [5:0] q, input logic [15:0] k,
                        input bit noise, input string tag);
    bit legal, rd, wr, prd, we;
    logic [15:0] a, wv;
    logic [1:0] ws;
    int ncyc;
    model(m, s, st, x, y, z, sp, q, k, legal, a, rd, wr, prd, we, ws, wv, ncyc);
    @(negedge clk);
    req_valid = 1; mode = m; ptr_sel = s; is_store = st; ptr_x = x; ptr_y = y;
    ptr_z = z; ptr_sp = sp; disp = q; direct_addr = k;
    @(negedge clk);
    if (legal && noise) begin
      // R2: fresh requests while busy must be ignored
      req_valid = 1; mode = m ^ 3'd3; ptr_x = ~x; ptr_y = ~y; ptr_z = ~z;
      ptr_sp = ~sp; direct_addr = ~k; disp = ~q;
    end else req_valid = 0;
    if (!legal) begin
      chk(!busy && !mem_rd && !mem_wr && !prog_rd && !wb_we, {tag, " R2 illegal ignored"},
          {busy, mem_rd, mem_wr, prog_rd, wb_we}, 0);
      return;
    end
    chk(busy && !done, {tag, " R9 busy first"}, {busy, done}, 2'b10);
    chk(mem_addr == a, {tag, " addr"}, mem_addr, a);
    chk({mem_rd, mem_wr, prog_rd} == {rd, wr, prd}, {tag, " R8 strobes"},
        {mem_rd, mem_wr, prog_rd}, {rd, wr, prd});
    chk(wb_we == we, {tag, " R12 wb_we"}, wb_we, we);
    if (we) begin
      chk(wb_sel == ws, {tag, " R12 wb_sel"}, wb_sel, ws);
      chk(wb_val == wv, {tag, " wb_val"}, wb_val, wv);
    end
    chk(!r0_we, {tag, " R10 r0 early"}, r0_we, 0);
    for (int i = 2; i <= ncyc; i++) begin
      @(negedge clk);
      chk(busy && (done == (i == ncyc)), {tag, " R9 count"}, {busy, done},
          {1'b1, i == ncyc});
      chk(!mem_rd && !mem_wr && !prog_rd && !wb_we, {tag, " R8 single strobe"},
          {mem_rd, mem_wr, prog_rd, wb_we}, 0);
      chk(mem_addr == a, {tag, " R9 addr hold"}, mem_addr, a);
      chk(r0_we == (prd && i == ncyc), {tag, " R10 r0_we"}, r0_we, prd && i == ncyc);
      if (i == ncyc) req_valid = 0;
    end
    @(negedge clk);
    chk(!busy && !done, {tag, " R9 idle after"}, {busy, done}, 0);
  endtask

  initial begin
    #(10 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst = 1; req_valid = 0; is_store = 0; mode = 0; ptr_sel = 0; disp = 0;
    direct_addr = 0; ptr_x = 0; ptr_y = 0; ptr_z = 0; ptr_sp = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_rd && !mem_wr && !prog_rd && !wb_we && !r0_we,
        "R1 reset", {busy, done, mem_rd, mem_wr, prog_rd, wb_we, r0_we}, 0);
    rst = 0;
    run_op(3'd0, 2'd0, 0, 16'h1234, 16'h0, 16'h0, 16'h0, 6'd0, 16'h0, 0, "R3 ind X");
    run_op(3'd1, 2'd1, 0, 16'h0, 16'hFFFF, 16'h0, 16'h0, 6'd0, 16'h0, 0, "R4 postinc wrap");
    run_op(3'd2, 2'd2, 1, 16'h0, 16'h0, 16'h0000, 16'h0, 6'd0, 16'h0, 0, "R5 predec wrap");
    run_op(3'd3, 2'd1, 0, 16'h0, 16'hFFF0, 16'h0, 16'h0, 6'd63, 16'h0, 0, "R6 disp Y 63");
    run_op(3'd3, 2'd2, 1, 16'h0, 16'h0, 16'h4000, 16'h0, 6'd0, 16'h0, 0, "R6 disp Z 0");
    run_op(3'd3, 2'd0, 0, 16'h1000, 16'h0, 16'h0, 16'h0, 6'd5, 16'h0, 0, "R6 disp X");
    run_op(3'd1, 2'd3, 0, 16'h0, 16'h0, 16'h0, 16'h0100, 6'd0, 16'h0, 0, "R2 sel SP");
    run_op(3'd4, 2'd3, 1, 16'h0, 16'h0, 16'h0, 16'h0, 6'd0, 16'hBEEF, 0, "R7 direct");
    run_op(3'd5, 2'd0, 1, 16'h0, 16'h0, 16'h0ABC, 16'h0, 6'd0, 16'h0, 0, "R10 prog");
    run_op(3'd6, 2'd0, 0, 16'h0, 16'h0, 16'h0, 16'h0000, 6'd0, 16'h0, 0, "R11 push");
    run_op(3'd7, 2'd1, 1, 16'h0, 16'h0, 16'h0, 16'hFFFF, 6'd0, 16'h0, 0, "R11 pop");
    run_op(3'd1, 2'd2, 1, 16'h0, 16'h0, 16'h8000, 16'h0, 6'd0, 16'h0, 1, "R2 busy noise");
    run_op(3'd5, 2'd1, 0, 16'h0, 16'h0, 16'h7777, 16'h0, 6'd0, 16'h0, 1, "R2 noise prog");
    for (int n = 0; n < 400; n++) begin
      run_op(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
             6'($urandom), 16'($urandom), bit'($urandom_range(0, 1)), "rand");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule